// File: doc/BRIEF.md
# SPI Serial SRAM Host Controller

This block is the host side of an SPI link to a serial SRAM. A client hands it one command at a time on a valid/ready request port. A command names a kind (data read, data write, mode-register read or mode-register write), a start address, a byte count and, for a mode write, the new register value. Write data enters as a byte stream with its own valid/ready pair. Read data leaves as a byte stream with a one-cycle valid pulse per byte. Every command ends with a one-cycle completion pulse that carries an error code.

The controller checks each request before it touches the bus. The start address is compared against the capacity fixed by a parameter (8K, 32K, 64K or 128K bytes). The byte count is compared against the limits of the operating mode held in a local shadow of the memory's mode register. The shadow changes only when a mode write completes on the bus. A rejected request returns its error code and leaves chip select high.

SCLK is the system clock divided by an even parameter, in SPI mode 0. A hold input pauses a running transfer: SCLK freezes low, the HOLD pin goes low, chip select stays low, and the transfer resumes where it stopped.

Top module: `sram_spi_host`

## Requirements
- R1: A command is framed as an opcode byte (read 0x03, write 0x02, mode read 0x05, mode write 0x01), then for data commands the address MSB first in 2 bytes when the capacity is at most 64K and 3 bytes when it is 128K, then the data bytes. SCLK idles low, MOSI changes on falling edges and MISO is sampled on rising edges, so a data command of N bytes gives exactly 8*(1+address bytes+N) rising SCLK edges.
- R2: Bytes written from the write stream land at consecutive addresses from the start address, and a later read of the same range returns them in order on the read stream.
- R3: A data request whose start address is at or above the capacity completes with error code 1 and no chip-select activity.
- R4: In byte mode (mode bits [7:6] = 00) a data request longer than one byte completes with error code 2 and no bus activity, and a one-byte request is carried out.
- R5: In page mode (mode bits = 10) a data request completes with error code 2 when (start address mod 32) + length exceeds 32; a full 32-byte page from a page-aligned address is carried out.
- R6: In sequential mode (mode bits = 01) any non-zero length within range is carried out, including runs that cross 32-byte page boundaries.
- R7: A mode write whose value has bits [7:6] = 11 completes with error code 3, causes no bus activity and leaves the shadow mode unchanged.
- R8: A data request of length zero completes with error code 2 and no bus activity.
- R9: While hold is requested during a transfer, SCLK stays low, HOLD is driven low and chip select stays low; after release the transfer finishes with correct data.
- R10: Chip select stays high for at least one SCLK period (the clock divisor, in system cycles) between commands. SCLK is low whenever chip select is high.
- R11: After reset the shadow mode is byte mode, chip select is high and the request port is ready. The shadow takes the new mode only after a mode write completes without error. A mode read returns the memory's register on the read stream.
- R12: A command that is carried out completes with error code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_kind | input | 2 | 0 read, 1 write, 2 mode read, 3 mode write |
| req_addr | input | ADDR_W | Start address (16 bits by default) |
| req_len | input | LEN_W | Byte count for data commands |
| req_mode | input | 8 | Value for a mode write |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Controller takes the write byte this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid, one cycle |
| rd_data | output | 8 | Read byte |
| done_valid | output | 1 | Command completed, one cycle |
| done_err | output | 2 | 0 ok, 1 address, 2 length, 3 mode value |
| hold_req | input | 1 | Pause the running transfer |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |
| spi_hold_n | output | 1 | Hold pin, active low |

## Verification
The bench goes after the edges of each mode's length rule: a two-byte request in byte mode, a page run that ends exactly on a page boundary against one that crosses it by one byte, the last and first-illegal addresses of the capacity, and a zero length. A design with an off-by-one in the page sum would reject the exact page or let the crossing run onto the bus, and a wrong capacity compare would let the first address past the end through or refuse the last one. A reserved mode write is followed by a length probe, which shows whether the shadow was corrupted. A hold placed in the middle of an address byte shows whether SCLK keeps running or bits are lost on resume.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;

   typedef enum logic [1:0] {
      K_READ   = 2'd0,
      K_WRITE  = 2'd1,
      K_RDMODE = 2'd2,
      K_WRMODE = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      E_NONE = 2'd0,
      E_ADDR = 2'd1,
      E_LEN  = 2'd2,
      E_MODE = 2'd3
   } err_e;

   // mode-register field [7:6]
   localparam logic [1:0] M_BYTE = 2'b00;
   localparam logic [1:0] M_SEQ  = 2'b01;
   localparam logic [1:0] M_PAGE = 2'b10;
   localparam logic [1:0] M_RSVD = 2'b11;

   localparam int PAGE_BYTES = 32;

   function automatic logic [7:0] opcode_of(input logic [1:0] k);
      case (k)
         K_READ:   return 8'h03;
         K_WRITE:  return 8'h02;
         K_RDMODE: return 8'h05;
         default:  return 8'h01;
      endcase
   endfunction

endpackage

// File: rtl/sram_req_check.sv
module sram_req_check
   import sram_spi_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int LEN_W     = 16,
   parameter int CAP_BYTES = 8192
) (
   input  logic [1:0]        kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   input  logic [7:0]        mode_val,
   input  logic [1:0]        cur_mode,
   output logic [1:0]        err
);

   localparam logic [ADDR_W:0] CAP_V  = (ADDR_W+1)'(CAP_BYTES);
   localparam logic [LEN_W:0]  PAGE_V = (LEN_W+1)'(PAGE_BYTES);

   if (LEN_W < 6) begin : g_bad_len
      $error("LEN_W must cover a full page count");
   end

   logic [LEN_W:0] page_end;
   assign page_end = {{(LEN_W-4){1'b0}}, addr[4:0]} + {1'b0, len};

   always_comb begin
      err = E_NONE;
      if (kind == K_WRMODE) begin
         if (mode_val[7:6] == M_RSVD) err = E_MODE;
      end else if (kind == K_READ || kind == K_WRITE) begin
         if ({1'b0, addr} >= CAP_V)            err = E_ADDR;
         else if (len == '0)                   err = E_LEN;
         else begin
            case (cur_mode)
               M_BYTE:  if (len > LEN_W'(1))   err = E_LEN;
               M_PAGE:  if (page_end > PAGE_V) err = E_LEN;
               M_SEQ:   err = E_NONE;
               default: err = E_MODE;
            endcase
         end
      end
   end

endmodule

// File: rtl/sram_spi_shifter.sv
module sram_spi_shifter #(
   parameter int CLK_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld,
   input  logic [7:0] tx,
   input  logic       hold,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx
);

   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be even and at least 2");
   end

   logic          busy_q, sclk_q, done_q;
   logic [CW-1:0] cnt_q;
   logic [2:0]    bit_q;
   logic [7:0]    sh_q, rx_q;
   logic          frozen;

   assign frozen = hold && !sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
         bit_q  <= '0;
         sh_q   <= '0;
         rx_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (ld) begin
            busy_q <= 1'b1;
            sh_q   <= tx;
            sclk_q <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
         end else if (busy_q && !frozen) begin
            if (cnt_q == CW'(HALF-1)) begin
               cnt_q <= '0;
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
                  rx_q   <= {rx_q[6:0], miso};
               end else begin
                  sclk_q <= 1'b0;
                  if (bit_q == 3'd7) begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     bit_q <= bit_q + 3'd1;
                     sh_q  <= {sh_q[6:0], 1'b0};
                  end
               end
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   end

   assign sclk = sclk_q;
   assign mosi = sh_q[7];
   assign done = done_q;
   assign rx   = rx_q;

   p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !sclk_q) |=> !sclk_q);

   p_byte_ends_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !sclk_q);

endmodule

// File: rtl/sram_spi_host.sv
module sram_spi_host
   import sram_spi_pkg::*;
#(
   parameter int         CAP_BYTES = 8192,
   parameter int         CLK_DIV   = 4,
   parameter int         LEN_W     = 16,
   parameter logic [7:0] MODE_RST  = 8'h00,
   localparam int        ADDR_BYTES = (CAP_BYTES > 65536) ? 3 : 2,
   localparam int        ADDR_W     = 8 * ADDR_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [7:0]        req_mode,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [7:0]        wr_data,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              done_valid,
   output logic [1:0]        done_err,
   input  logic              hold_req,
   output logic              spi_cs_n,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_hold_n
);

   localparam int GW = $clog2(CLK_DIV + 1);

   if (CAP_BYTES != 8192 && CAP_BYTES != 32768 &&
       CAP_BYTES != 65536 && CAP_BYTES != 131072) begin : g_bad_cap
      $error("CAP_BYTES must be 8K, 32K, 64K or 128K");
   end

   typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADR, S_DAT, S_GAP, S_FIN} state_e;

   state_e            state_q;
   logic [1:0]        kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  rem_q;
   logic [7:0]        mval_q, shadow_q, rd_q;
   logic [1:0]        idx_q, err_q;
   logic              pend_q, cs_n_q, rdv_q;
   logic [GW-1:0]     gap_q;

   logic [1:0] chk_err;
   logic       ld, sh_done, sh_sclk, src_ok, is_rd;
   logic [7:0] tx, addr_byte, sh_rx;

   sram_req_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CAP_BYTES(CAP_BYTES)) u_chk (
      .kind     (req_kind),
      .addr     (req_addr),
      .len      (req_len),
      .mode_val (req_mode),
      .cur_mode (shadow_q[7:6]),
      .err      (chk_err)
   );

   sram_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shf (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ld),
      .tx    (tx),
      .hold  (hold_req),
      .miso  (spi_miso),
      .sclk  (sh_sclk),
      .mosi  (spi_mosi),
      .done  (sh_done),
      .rx    (sh_rx)
   );

   // address byte select, MSB sent first
   if (ADDR_BYTES == 3) begin : g_addr24
      always_comb begin
         case (idx_q)
            2'd2:    addr_byte = addr_q[23:16];
            2'd1:    addr_byte = addr_q[15:8];
            default: addr_byte = addr_q[7:0];
         endcase
      end
   end else begin : g_addr16
      assign addr_byte = idx_q[0] ? addr_q[15:8] : addr_q[7:0];
   end

   assign is_rd  = (kind_q == K_READ) || (kind_q == K_RDMODE);
   assign src_ok = (state_q == S_DAT && kind_q == K_WRITE) ? wr_valid : 1'b1;
   assign ld     = pend_q && src_ok &&
                   (state_q == S_OPC || state_q == S_ADR || state_q == S_DAT);

   always_comb begin
      case (state_q)
         S_OPC:   tx = opcode_of(kind_q);
         S_ADR:   tx = addr_byte;
         S_DAT:   tx = (kind_q == K_WRITE)  ? wr_data :
                       (kind_q == K_WRMODE) ? mval_q  : 8'h00;
         default: tx = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         kind_q   <= K_READ;
         addr_q   <= '0;
         rem_q    <= '0;
         mval_q   <= '0;
         shadow_q <= MODE_RST;
         rd_q     <= '0;
         idx_q    <= '0;
         err_q    <= E_NONE;
         pend_q   <= 1'b0;
         cs_n_q   <= 1'b1;
         rdv_q    <= 1'b0;
         gap_q    <= '0;
      end else begin
         rdv_q <= 1'b0;
         if (ld) pend_q <= 1'b0;
         case (state_q)
            S_IDLE: if (req_valid) begin
               kind_q <= req_kind;
               addr_q <= req_addr;
               rem_q  <= req_len;
               mval_q <= req_mode;
               err_q  <= chk_err;
               if (chk_err != E_NONE) begin
                  state_q <= S_FIN;
               end else begin
                  cs_n_q  <= 1'b0;
                  pend_q  <= 1'b1;
                  state_q <= S_OPC;
               end
            end
            S_OPC: if (sh_done) begin
               pend_q <= 1'b1;
               if (kind_q == K_RDMODE || kind_q == K_WRMODE) begin
                  rem_q   <= LEN_W'(1);
                  state_q <= S_DAT;
               end else begin
                  idx_q   <= 2'(ADDR_BYTES - 1);
                  state_q <= S_ADR;
               end
            end
            S_ADR: if (sh_done) begin
               pend_q <= 1'b1;
               if (idx_q == 2'd0) state_q <= S_DAT;
               else               idx_q   <= idx_q - 2'd1;
            end
            S_DAT: if (sh_done) begin
               if (is_rd) begin
                  rdv_q <= 1'b1;
                  rd_q  <= sh_rx;
               end
               if (kind_q == K_WRMODE) shadow_q <= mval_q;
               if (rem_q == LEN_W'(1)) begin
                  cs_n_q  <= 1'b1;
                  gap_q   <= '0;
                  state_q <= S_GAP;
               end else begin
                  rem_q  <= rem_q - LEN_W'(1);
                  pend_q <= 1'b1;
               end
            end
            S_GAP: begin
               gap_q <= gap_q + GW'(1);
               if (gap_q == GW'(CLK_DIV - 1)) state_q <= S_FIN;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready  = (state_q == S_IDLE);
   assign wr_ready   = pend_q && (state_q == S_DAT) && (kind_q == K_WRITE);
   assign rd_valid   = rdv_q;
   assign rd_data    = rd_q;
   assign done_valid = (state_q == S_FIN);
   assign done_err   = err_q;
   assign spi_cs_n   = cs_n_q;
   assign spi_sclk   = sh_sclk;
   assign spi_hold_n = !(hold_req && !cs_n_q && !sh_sclk);

   p_idle_sclk_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   p_reject_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && req_valid && chk_err != E_NONE) |=> (spi_cs_n && done_valid));

   p_shadow_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shadow_q[7:6] != M_RSVD);

   p_hold_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_hold_n |-> (!spi_cs_n && !spi_sclk));

   p_read_stream_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> is_rd);

   p_gap_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |=> spi_cs_n);

endmodule

// File: tb/sram_spi_host_tb.sv
module sram_spi_host_tb;

   localparam int CAP = 8192;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_kind = '0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_len = '0;
   logic [7:0]  req_mode = '0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [7:0]  wr_data = '0;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic        done_valid;
   logic [1:0]  done_err;
   logic        hold_req = 1'b0;
   logic        spi_cs_n, spi_sclk, spi_mosi, spi_hold_n;
   logic        spi_miso = 1'b0;

   always #10 clk = ~clk;

   sram_spi_host #(.CAP_BYTES(CAP), .CLK_DIV(DIV), .LEN_W(16), .MODE_RST(8'h00)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_addr(req_addr), .req_len(req_len), .req_mode(req_mode),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .done_valid(done_valid), .done_err(done_err), .hold_req(hold_req),
      .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_hold_n(spi_hold_n)
   );

   int n_checks = 0;
   int n_err = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- memory model on the bus ----------------
   logic [7:0] mem [0:CAP-1];
   logic [7:0] s_sh = '0, s_opc = '0, s_ob = '0, s_mode = 8'h00;
   int s_bc = 0, s_addr = 0, last_opc = -1, last_addr = -1;
   int cs_falls = 0, sclk_rises = 0;

   always @(negedge spi_cs_n) begin
      s_bc = 0;
      s_addr = 0;
      cs_falls++;
   end

   always @(posedge spi_sclk) begin
      sclk_rises++;
      if (!spi_cs_n) begin
         s_sh = {s_sh[6:0], spi_mosi};
         s_bc++;
         if (s_bc % 8 == 0) begin
            if (s_bc == 8) begin
               s_opc = s_sh;
               last_opc = int'(s_sh);
            end else if (s_opc == 8'h01 && s_bc == 16) begin
               s_mode = s_sh;
            end else if (s_opc == 8'h02 || s_opc == 8'h03) begin
               if (s_bc <= 24) begin
                  s_addr = (s_addr << 8) | int'(s_sh);
                  if (s_bc == 24) last_addr = s_addr;
               end else begin
                  if (s_opc == 8'h02) mem[s_addr % CAP] = s_sh;
                  s_addr++;
               end
            end
         end
      end
   end

   always @(negedge spi_sclk) begin
      if (!spi_cs_n && ((s_opc == 8'h03 && s_bc >= 24) || (s_opc == 8'h05 && s_bc >= 8))) begin
         if (s_bc % 8 == 0) begin
            s_ob = (s_opc == 8'h05) ? s_mode : mem[s_addr % CAP];
            spi_miso = s_ob[7];
         end else begin
            spi_miso = s_ob[7 - (s_bc % 8)];
         end
      end
   end

   // chip-select gap monitor (R10)
   int hi_cnt = 0;
   logic prev_cs = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_cs && !spi_cs_n)
            check(hi_cnt >= DIV, "R10", "cs high gap", hi_cnt, DIV);
         if (spi_cs_n) hi_cnt++; else hi_cnt = 0;
         if (spi_cs_n && spi_sclk) check(0, "R10", "sclk high while deselected", 1, 0);
      end
      prev_cs = spi_cs_n;
   end

   // ---------------- command driver ----------------
   logic [7:0] wbuf [0:63];
   logic [7:0] rbuf [0:63];
   int rcount = 0;

   task automatic run_cmd(input logic [1:0] kind, input int addr, input int len,
                          input logic [7:0] mval, output int err);
      int widx = 0;
      bit hs = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_kind = kind;
      req_addr = 16'(addr);
      req_len = 16'(len);
      req_mode = mval;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      rcount = 0;
      forever begin
         if (hs) widx++;
         wr_data = wbuf[widx % 64];
         wr_valid = (kind == 2'd1) && (widx < len);
         hs = wr_valid && wr_ready;
         if (rd_valid) begin
            rbuf[rcount % 64] = rd_data;
            rcount++;
         end
         if (done_valid) begin
            err = int'(done_err);
            break;
         end
         @(negedge clk);
      end
      wr_valid = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int a, input int n);
      return 8'((a * 13 + n * 5 + 7) & 255);
   endfunction

   // write then read back a range, checking framing and data
   task automatic wr_rd(input int addr, input int len, input string rq);
      int e, r0, f0;
      for (int i = 0; i < len; i++) wbuf[i] = pat(addr + i, len);
      r0 = sclk_rises;
      run_cmd(2'd1, addr, len, 8'h00, e);
      check(e == 0, "R12", {rq, " write status"}, e, 0);
      check(sclk_rises - r0 == 8 * (3 + len), "R1", "write edge count", sclk_rises - r0, 8 * (3 + len));
      check(last_opc == 2 && last_addr == addr, "R1", "write opcode/address", last_addr, addr);
      f0 = sclk_rises;
      run_cmd(2'd0, addr, len, 8'h00, e);
      check(e == 0, "R12", {rq, " read status"}, e, 0);
      check(last_opc == 3 && rcount == len, "R1", "read opcode/count", rcount, len);
      check(sclk_rises - f0 == 8 * (3 + len), "R1", "read edge count", sclk_rises - f0, 8 * (3 + len));
      for (int i = 0; i < len; i++)
         check(rbuf[i] == pat(addr + i, len), rq, "readback", int'(rbuf[i]), int'(pat(addr + i, len)));
   endtask

   task automatic expect_reject(input logic [1:0] kind, input int addr, input int len,
                                input logic [7:0] mval, input int code, input string rq);
      int e, c0;
      c0 = cs_falls;
      run_cmd(kind, addr, len, mval, e);
      check(e == code, rq, "reject code", e, code);
      check(cs_falls == c0, rq, "no bus on reject", cs_falls - c0, 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog (all): cycles=%0d expected below %0d", 190000, 190000);
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   // ---------------- sequence ----------------
   initial begin
      int e, bad, r0;
      for (int i = 0; i < CAP; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R11", "reset bus idle", int'(spi_cs_n), 1);
      check(req_ready == 1'b1 && done_valid == 1'b0, "R11", "reset ready", int'(req_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(spi_hold_n == 1'b1, "R11", "hold pin idle", int'(spi_hold_n), 1);

      // byte mode after reset (R11, R4)
      expect_reject(2'd0, 16'h10, 2, 8'h00, 2, "R4");
      wr_rd(CAP - 1, 1, "R4");
      expect_reject(2'd1, CAP, 1, 8'h00, 1, "R3");
      expect_reject(2'd0, 16'hFFFF, 1, 8'h00, 1, "R3");
      expect_reject(2'd1, 16'h20, 0, 8'h00, 2, "R8");

      // reserved mode value refused, shadow unchanged (R7)
      expect_reject(2'd3, 0, 0, 8'hC0, 3, "R7");
      expect_reject(2'd0, 16'h10, 2, 8'h00, 2, "R7");

      // page mode (R5, R11)
      run_cmd(2'd3, 0, 0, 8'h80, e);
      check(e == 0 && s_mode == 8'h80, "R11", "mode write lands", int'(s_mode), 8'h80);
      run_cmd(2'd2, 0, 0, 8'h00, e);
      check(e == 0 && rcount == 1 && rbuf[0] == 8'h80, "R11", "mode read", int'(rbuf[0]), 8'h80);
      expect_reject(2'd1, 30, 3, 8'h00, 2, "R5");
      expect_reject(2'd0, 16'h5F, 2, 8'h00, 2, "R5");
      wr_rd(16'h40, 32, "R5");
      wr_rd(16'h7E, 2, "R5");
      wr_rd(16'h9F, 1, "R5");

      // sequential mode sweep (R6, R2)
      run_cmd(2'd3, 0, 0, 8'h40, e);
      check(e == 0 && s_mode == 8'h40, "R11", "mode write seq", int'(s_mode), 8'h40);
      for (int a = 0; a < 3; a++)
         for (int n = 1; n <= 8; n++)
            wr_rd((a == 0) ? 16'h100 : (a == 1) ? 16'h1C : CAP - 8, n, "R6");
      wr_rd(16'h3F0, 40, "R2");
      expect_reject(2'd0, 16'h200, 0, 8'h00, 2, "R8");

      // hold in mid transfer (R9)
      for (int i = 0; i < 4; i++) mem[16'h500 + i] = 8'hA0 + 8'(i);
      bad = 0;
      fork
         run_cmd(2'd0, 16'h500, 4, 8'h00, e);
         begin
            repeat (60) @(negedge clk);
            hold_req = 1'b1;
            repeat (DIV) @(negedge clk);
            check(spi_hold_n == 1'b0 && spi_cs_n == 1'b0, "R9", "hold pin low, cs kept", int'(spi_hold_n), 0);
            r0 = sclk_rises;
            for (int k = 0; k < 30; k++) begin
               if (spi_sclk) bad++;
               @(negedge clk);
            end
            check(bad == 0 && sclk_rises == r0, "R9", "sclk frozen", bad, 0);
            hold_req = 1'b0;
         end
      join
      check(e == 0 && rcount == 4, "R9", "held read status", rcount, 4);
      for (int i = 0; i < 4; i++)
         check(rbuf[i] == 8'hA0 + 8'(i), "R9", "held read data", int'(rbuf[i]), 8'hA0 + i);

      repeat (10) @(negedge clk);
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule